// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Data Register

This block sits behind a user-defined JTAG instruction and turns one Shift-DR pass into one complete SPI flash transaction. While the bridge instruction is selected and the TAP is shifting, the block watches TDI. It skips every leading zero, because those zeros come from the bypass registers of TAPs that sit ahead of it in the chain. The first one bit it sees is a start marker. The next `LEN_W` bits form a transfer-length word, and that word sets how long the chip-select window stays open.

During the window, TDI is passed straight through to MOSI. SCK is a gated copy of TCK, so the SPI side runs in mode 0: the flash samples on the rising edge, and MOSI and MISO change on the falling edge. MISO returns to TDO through a single register stage. Once the window has closed, the block ignores any further shift cycles. Those extra cycles only carry the returned read data through the downstream bypass registers to the host. Capture-DR, Update-DR, a deselected instruction or a reset puts the block back into marker-hunting idle.

Top module: `jtag_spi_bridge`

## Requirements
- R1: Every zero on TDI during Shift-DR while the block is idle is ignored. SPI chip select stays high and no SCK edge occurs, whatever the number of leading zeros.
- R2: The first one bit is the start marker. The `LEN_W` (32) bits after it are the length word, most significant bit first.
- R3: After the length word, `spi_cs_n` stays low for exactly length+1 TCK periods, and `spi_sck` gives exactly length+1 rising edges inside that window.
- R4: While chip select is low, `spi_mosi` equals TDI, so the flash receives frame bits in shift order at rising SCK edges (SPI mode 0).
- R5: During the window, TDO in each cycle shows the MISO value sampled at the previous rising TCK edge (one register stage).
- R6: After the window closes, further shift cycles, including one bits, do not start another transaction until the block has returned to idle.
- R7: Capture-DR, Update-DR, `sel` low or `rst` high returns the block to idle with chip select high on the following clock edges.
- R8: TDO is 0 whenever no transfer window is active.
- R9: `spi_sck` stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | TCK |
| rst | input | 1 | Synchronous active-high reset (TAP reset) |
| sel | input | 1 | Bridge instruction is selected |
| capture | input | 1 | TAP in Capture-DR |
| shift | input | 1 | TAP in Shift-DR |
| update | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in from the chain |
| tdo | output | 1 | Serial data out to the chain |
| spi_miso | input | 1 | Flash data out |
| spi_sck | output | 1 | Gated SPI clock |
| spi_mosi | output | 1 | Flash data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two things are hard to bring about from the ports. One is the exact alignment between the chip-select edges, which change on falling TCK, and the read bits coming back on TDO. The other is an abort that arrives in the middle of a window. The bench places a flash model on the SPI pins that answers a read-ID command. It runs frames with zero, one and three leading zeros and lines up the returned ID bit by bit. It also opens long windows and cuts them short with Capture-DR or with the instruction deselected. A monitor counts the chip-select low cycles and the SCK edges for every window and compares them against the lengths queued by the driver.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEN  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } bridge_state_e;

    function automatic logic leave_idle(input logic capture, input logic update, input logic sel);
        return capture | update | ~sel;
    endfunction
endpackage

// File: rtl/jsb_frame_ctrl.sv
module jsb_frame_ctrl
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    output bridge_state_e state_o
);
    localparam int CNT_W = $clog2(LEN_W);
    localparam logic [CNT_W-1:0] LAST_LEN_BIT = CNT_W'(LEN_W - 1);

    bridge_state_e    state_q;
    logic [CNT_W-1:0] bitcnt_q;
    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || leave_idle(capture, update, sel)) begin
            state_q  <= ST_HUNT;
            bitcnt_q <= '0;
            remain_q <= '0;
        end else if (shift) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (tdi) begin
                        state_q  <= ST_LEN;
                        bitcnt_q <= '0;
                    end
                end
                ST_LEN: begin
                    remain_q <= {remain_q[LEN_W-2:0], tdi};
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == LAST_LEN_BIT) state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (remain_q == '0) state_q <= ST_DONE;
                    else                remain_q <= remain_q - 1'b1;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/jsb_spi_gate.sv
module jsb_spi_gate (
    input  logic clk,
    input  logic rst,
    input  logic in_window,
    input  logic shift,
    input  logic tdi,
    output logic spi_sck,
    output logic spi_mosi,
    output logic spi_cs_n
);
    logic sck_en_q;
    logic cs_n_q;

    // Falling-edge update keeps the gated clock free of glitches.
    always_ff @(negedge clk) begin
        if (rst) begin
            sck_en_q <= 1'b0;
            cs_n_q   <= 1'b1;
        end else begin
            sck_en_q <= in_window & shift;
            cs_n_q   <= ~in_window;
        end
    end

    assign spi_sck  = clk & sck_en_q;
    assign spi_mosi = tdi & ~cs_n_q;
    assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/jsb_tdo_stage.sv
module jsb_tdo_stage (
    input  logic clk,
    input  logic rst,
    input  logic in_window,
    input  logic shift,
    input  logic spi_miso,
    output logic tdo
);
    logic tdo_q;

    always_ff @(posedge clk) begin
        if (rst)                     tdo_q <= 1'b0;
        else if (in_window && shift) tdo_q <= spi_miso;
        else                         tdo_q <= 1'b0;
    end

    assign tdo = tdo_q;
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic tdo,
    input  logic spi_miso,
    output logic spi_sck,
    output logic spi_mosi,
    output logic spi_cs_n
);
    bridge_state_e st;
    logic          in_window;

    jsb_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture),
        .shift(shift), .update(update), .tdi(tdi), .state_o(st)
    );

    assign in_window = (st == ST_XFER);

    jsb_spi_gate u_gate (
        .clk(clk), .rst(rst), .in_window(in_window), .shift(shift), .tdi(tdi),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    jsb_tdo_stage u_tdo (
        .clk(clk), .rst(rst), .in_window(in_window), .shift(shift),
        .spi_miso(spi_miso), .tdo(tdo)
    );
endmodule

// File: rtl/jtag_spi_bridge_chk.sv
module jtag_spi_bridge_chk
    import jsb_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          capture,
    input logic          shift,
    input logic          update,
    input logic          tdi,
    input logic          tdo,
    input logic          spi_miso,
    input bridge_state_e st
);
    logic calm;
    assign calm = sel & ~capture & ~update;

    p_zero_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT && shift && !tdi) |=> (st == ST_HUNT));

    p_marker_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT && shift && tdi && calm) |=> (st == ST_LEN));

    p_tdo_path_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_XFER && shift) |=> (tdo == $past(spi_miso)));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && calm) |=> (st == ST_DONE));

    p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!calm) |=> (st == ST_HUNT));

    p_tdo_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st != ST_XFER) |=> (tdo == 1'b0));
endmodule

bind jtag_spi_bridge jtag_spi_bridge_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .spi_miso(spi_miso), .st(st)
);

// File: tb/jtag_spi_bridge_tb.sv
module jtag_spi_bridge_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b1, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic tdo, spi_miso, spi_sck, spi_mosi, spi_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    int cs_cyc = 0, sck_cnt = 0, sck_stray = 0;

    localparam logic [23:0] FLASH_ID = 24'hC2_20_17;

    always #4 clk = ~clk;

    jtag_spi_bridge u_dut (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
        .update(update), .tdi(tdi), .tdo(tdo), .spi_miso(spi_miso),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    // Flash model: answers the read-ID command 0x9F, mode 0
    logic [7:0] fl_cmd = 8'h00;
    int         fl_cnt = 0;
    initial spi_miso = 1'b0;
    always @(negedge spi_cs_n) fl_cnt = 0;
    always @(posedge spi_cs_n) spi_miso = 1'b0;
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (fl_cnt < 8) fl_cmd = {fl_cmd[6:0], spi_mosi};
        fl_cnt++;
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        if (fl_cmd == 8'h9F && fl_cnt >= 8 && fl_cnt < 32) spi_miso = FLASH_ID[31 - fl_cnt];
        else spi_miso = 1'b0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: window length and SCK edges per transaction
    always @(posedge clk) if (mon_on && !spi_cs_n) cs_cyc++;
    always @(posedge spi_sck) if (mon_on) begin
        if (spi_cs_n) sck_stray++;
        else          sck_cnt++;
    end
    always @(posedge spi_cs_n) if (mon_on) begin
        if (exp_q.size() == 0) begin
            check("R6 unexpected window", 32'(cs_cyc), 32'd0);
        end else begin
            int e;
            e = exp_q.pop_front();
            check("R3 cs low cycles", 32'(cs_cyc), 32'(e));
            check("R3 sck rising edges", 32'(sck_cnt), 32'(e));
        end
        cs_cyc = 0;
        sck_cnt = 0;
    end

    task automatic tick(input logic b, output logic t);
        tdi = b;
        @(posedge clk);
        @(negedge clk);
        #1;
        t = tdo;
    endtask

    task automatic begin_scan();
        capture = 1'b1; shift = 1'b0;
        @(negedge clk); #1;
        capture = 1'b0; shift = 1'b1;
    endtask

    task automatic end_scan();
        shift = 1'b0; update = 1'b1; tdi = 1'b0;
        @(negedge clk); #1;
        update = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic send_header(input int lead, input logic [31:0] len);
        logic t;
        for (int i = 0; i < lead; i++) begin
            tick(1'b0, t);
            check("R1 cs high during leading zeros", 32'(spi_cs_n), 32'd1);
        end
        tick(1'b1, t);
        for (int i = 31; i >= 0; i--) tick(len[i], t);
    endtask

    task automatic run_read_id(input int lead);
        logic t;
        logic [23:0] got = '0;
        logic [7:0] cmd = 8'h9F;
        exp_q.push_back(32);
        begin_scan();
        send_header(lead, 32'd31);
        for (int j = 0; j < 32; j++) begin
            tick(j < 8 ? cmd[7 - j] : 1'b0, t);
            if (j >= 8) got = {got[22:0], t};
        end
        check($sformatf("R5 read ID lead=%0d", lead), 32'(got), 32'(FLASH_ID));
        check("R4 flash saw command", 32'(fl_cmd), 32'h9F);
        for (int j = 0; j < 4; j++) tick(1'b1, t);
        check("R6 no restart after window", 32'(spi_cs_n), 32'd1);
        check("R8 tdo zero after window", 32'(t), 32'd0);
        end_scan();
    endtask

    initial begin
        logic t;
        repeat (4) @(negedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk); #1;
        check("R7 reset cs high", 32'(spi_cs_n), 32'd1);
        check("R8 reset tdo zero", 32'(tdo), 32'd0);
        check("R9 reset sck low", 32'(spi_sck), 32'd0);
        mon_on = 1'b1;

        run_read_id(0);
        run_read_id(1);
        run_read_id(3);

        // write-style frame: 16 bits, length word 15
        exp_q.push_back(16);
        begin_scan();
        send_header(2, 32'd15);
        for (int j = 0; j < 16; j++) tick((16'h06A5 >> (15 - j)) & 1'b1, t);
        check("R4 write command byte", 32'(fl_cmd), 32'h06);
        end_scan();

        // minimal frame: length word 0 -> single bit
        exp_q.push_back(1);
        begin_scan();
        send_header(1, 32'd0);
        tick(1'b1, t);
        tick(1'b1, t);
        check("R3 single-bit window closed", 32'(spi_cs_n), 32'd1);
        end_scan();

        // abort by Capture-DR in mid-window
        exp_q.push_back(6);
        begin_scan();
        send_header(0, 32'd100);
        for (int j = 0; j < 5; j++) tick(1'b1, t);
        capture = 1'b1; shift = 1'b0;
        @(negedge clk); #1;
        capture = 1'b0;
        check("R7 capture aborts window", 32'(spi_cs_n), 32'd1);
        check("R8 tdo zero after abort", 32'(tdo), 32'd0);
        end_scan();

        // abort by instruction deselect
        exp_q.push_back(4);
        begin_scan();
        send_header(3, 32'd50);
        for (int j = 0; j < 3; j++) tick(1'b0, t);
        sel = 1'b0;
        @(negedge clk); #1;
        check("R7 deselect aborts window", 32'(spi_cs_n), 32'd1);
        sel = 1'b1;
        end_scan();

        repeat (4) @(negedge clk);
        check("R9 no sck while cs high", 32'(sck_stray), 32'd0);
        check("R3 all windows seen", 32'(exp_q.size()), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule